// File: doc/BRIEF.md
# Self-Timed Page Program and Erase Sequencer

This block performs the internal write cycles of a serial flash device once the serial front end has accepted a command and chip select has risen. The front end first announces a command with an opcode and an address. For a page program, it then streams data bytes into the block. The block collects these bytes in a page-sized buffer. Each byte goes to the next offset inside the addressed page, and the offset wraps at the page end. The block also records which offsets were loaded. When chip select rises on a byte boundary, the block commits the loaded offsets into the array and then holds busy for a time set by the number of bytes loaded.

Sector erase, chip erase and status write are started the same way and follow the same cycle pattern. There is first a sweep over the affected addresses, one address per clock, and then a timed hold. The status write has no sweep and no array writes. When a cycle ends, busy falls and a one-clock done pulse is issued, which upstream logic uses to clear write enable.

Protection decisions are made upstream. A command that reaches this block is already permitted. The only protection input is a per-sector lock mask, and it is honoured during chip erase.

The array is a behavioural byte-wide memory outside the block. It is reached through one port with a combinational read and a registered write. A program writes the old byte AND the new data. An erase writes 0xFF.

The data input is valid/ready:
- A byte transfers on a clock where both `in_valid` and `in_ready` are high.
- `in_ready` is high only while a program command is collecting data.
- `in_ready` drops in the cycle where `cs_rise` is high.
- A byte offered at any other time is not taken and has no effect.
- The block never stalls a collecting source.

Top module: `flash_wr_seq`

## Requirements
- R1: During and after reset, `busy`, `cycle_done`, `in_ready` and `mem_we` are all low.
- R2: `in_ready` is high only between a program `cmd_start` (`cmd_op` = 2'b00) and the next `cs_rise`. A byte offered with `in_valid` at any other time is not stored and does not change the array.
- R3: The k-th byte accepted (k from 0) is placed at page offset (`cmd_addr` low PAGE_W bits + k) mod 2^PAGE_W, inside the page named by the upper `cmd_addr` bits. A later byte at the same offset replaces the earlier one.
- R4: A program commit sets each loaded array byte to its old value AND the buffered byte. Offsets that were not loaded keep their contents.
- R5: A cycle starts only when `cs_rise` is high together with `cs_aligned`, and, for a program, only when at least one byte was loaded. Any other `cs_rise` discards the command: there is no busy period and no array write. `mem_we` is high only while busy.
- R6: A program holds `busy` for exactly 2^PAGE_W + n*T_PROG clocks, where n is the number of distinct offsets loaded.
- R7: Sector erase (`cmd_op` = 2'b01) writes 0xFF to every byte of the 2^SECT_W-byte sector that contains `cmd_addr`, whatever the offset. Other sectors are untouched. Busy lasts 2^SECT_W + T_SERASE clocks.
- R8: Chip erase (`cmd_op` = 2'b10) writes 0xFF to every sector whose bit in `sect_lock` (bit i for sector i, the sector being the upper ADDR_W-SECT_W address bits) is 0. Locked sectors are unchanged. Busy lasts 2^ADDR_W + T_CERASE clocks.
- R9: Status write (`cmd_op` = 2'b11) holds `busy` for T_STAT clocks and writes nothing to the array.
- R10: `cycle_done` is a single-clock pulse in the first clock after `busy` falls, and it occurs at no other time.
- R11: A `cmd_start` or `cs_rise` that arrives while busy is ignored. The running cycle keeps its length and no further cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-clock pulse announcing an accepted command |
| cmd_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 status write |
| cmd_addr | input | ADDR_W | Start address of the command |
| in_valid | input | 1 | Program data byte offered |
| in_ready | output | 1 | Block is collecting program data |
| in_data | input | 8 | Program data byte |
| cs_rise | input | 1 | One-clock pulse when chip select rises |
| cs_aligned | input | 1 | Chip select rose on a byte boundary (valid with cs_rise) |
| sect_lock | input | 2^(ADDR_W-SECT_W) | Per-sector lock mask used by chip erase |
| busy | output | 1 | Internal write cycle in progress |
| cycle_done | output | 1 | End-of-cycle pulse that clears write enable |
| mem_addr | output | ADDR_W | Array address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data at mem_addr, combinational |

## Verification
The bench builds the block with ADDR_W=10, PAGE_W=4 and SECT_W=8, which gives a 1 KiB array of four 256-byte sectors made of 16-byte pages. The cycle lengths are T_PROG=3, T_SERASE=20, T_CERASE=30 and T_STAT=7.

These settings make the sweep exhaustive. The bench programs every start offset with every length from one byte up to past a full page, so wrap and overwrite are exercised in every alignment. After each command it compares the whole array with its own model. The small sizes keep each chip erase short, so erases with and without locked sectors fit alongside the sweep.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'b00,
    OP_SERASE = 2'b01,
    OP_CERASE = 2'b10,
    OP_STAT   = 2'b11
  } wseq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ARMED,
    ST_SWEEP,
    ST_HOLD
  } wseq_st_e;

endpackage

// File: rtl/wseq_page_buf.sv
// Page staging buffer: data bytes plus a per-offset "loaded" mask.
module wseq_page_buf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [PAGE_W-1:0] start_off,
  input  logic              ld_en,
  input  logic [7:0]        ld_data,
  input  logic [PAGE_W-1:0] rd_off,
  output logic [7:0]        rd_data,
  output logic              rd_hit,
  output logic [PAGE_W:0]   loaded_cnt
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [7:0]        data_q [DEPTH];
  logic [DEPTH-1:0]  hit_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE_W:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (ld_en) data_q[ptr_q] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      hit_q <= '0;
      ptr_q <= start_off;
      cnt_q <= '0;
    end else if (ld_en) begin
      hit_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_q + 1'b1;   // wraps inside the page
      if (!hit_q[ptr_q]) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_data    = data_q[rd_off];
  assign rd_hit     = hit_q[rd_off];
  assign loaded_cnt = cnt_q;
endmodule

// File: rtl/wseq_ctrl.sv
// Command/cycle controller: arm, start on aligned CS rise, sweep, hold.
module wseq_ctrl
  import wseq_pkg::*;
#(
  parameter int          ADDR_W    = 17,
  parameter int          PAGE_W    = 8,
  parameter int          SECT_W    = 15,
  parameter int          HOLD_W    = 32,
  parameter int unsigned T_PROG    = 600,
  parameter int unsigned T_SERASE  = 30000,
  parameter int unsigned T_CERASE  = 105000,
  parameter int unsigned T_STAT    = 1800
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_start,
  input  wseq_op_e                 cmd_op,
  input  logic [ADDR_W-1:PAGE_W]   cmd_page,
  input  logic                     cs_rise,
  input  logic                     cs_aligned,
  input  logic [PAGE_W:0]          loaded_cnt,
  output wseq_op_e                 op_q,
  output logic [ADDR_W-1:PAGE_W]   page_q,
  output logic [ADDR_W-1:0]        sweep_idx,
  output logic                     in_sweep,
  output logic                     buf_clear,
  output logic                     in_ready,
  output logic                     busy,
  output logic                     cycle_done
);
  localparam int CW          = ADDR_W + 1;
  localparam int PAGE_BYTES  = 1 << PAGE_W;
  localparam int SECT_BYTES  = 1 << SECT_W;
  localparam int ARRAY_BYTES = 1 << ADDR_W;

  wseq_st_e          st_q;
  logic [CW-1:0]     swp_q;
  logic [CW-1:0]     sweep_len;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_len_q;
  logic [HOLD_W-1:0] hold_len_d;
  logic              start_ok;
  logic              armed;

  always_comb begin
    case (op_q)
      OP_PROG:   sweep_len = CW'(PAGE_BYTES);
      OP_SERASE: sweep_len = CW'(SECT_BYTES);
      OP_CERASE: sweep_len = CW'(ARRAY_BYTES);
      default:   sweep_len = '0;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_PROG:   hold_len_d = HOLD_W'(loaded_cnt) * HOLD_W'(T_PROG);
      OP_SERASE: hold_len_d = HOLD_W'(T_SERASE);
      OP_CERASE: hold_len_d = HOLD_W'(T_CERASE);
      default:   hold_len_d = HOLD_W'(T_STAT);
    endcase
  end

  assign armed    = (st_q == ST_LOAD) || (st_q == ST_ARMED);
  assign start_ok = cs_rise && cs_aligned &&
                    ((op_q != OP_PROG) || (loaded_cnt != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_PROG;
      page_q     <= '0;
      swp_q      <= '0;
      hold_q     <= '0;
      hold_len_q <= '0;
      cycle_done <= 1'b0;
    end else begin
      cycle_done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_start) begin
            op_q   <= cmd_op;
            page_q <= cmd_page;
            st_q   <= (cmd_op == OP_PROG) ? ST_LOAD : ST_ARMED;
          end
        end
        ST_LOAD, ST_ARMED: begin
          if (cs_rise) begin
            if (start_ok) begin
              swp_q      <= '0;
              hold_q     <= '0;
              hold_len_q <= hold_len_d;
              st_q       <= (op_q == OP_STAT) ? ST_HOLD : ST_SWEEP;
            end else begin
              st_q <= ST_IDLE;          // misaligned or empty: drop
            end
          end
        end
        ST_SWEEP: begin
          if (swp_q == sweep_len - CW'(1)) st_q <= ST_HOLD;
          else                             swp_q <= swp_q + CW'(1);
        end
        ST_HOLD: begin
          if (hold_q == hold_len_q - HOLD_W'(1)) begin
            st_q       <= ST_IDLE;
            cycle_done <= 1'b1;
          end else begin
            hold_q <= hold_q + HOLD_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sweep_idx = swp_q[ADDR_W-1:0];
  assign in_sweep  = (st_q == ST_SWEEP);
  assign busy      = (st_q == ST_SWEEP) || (st_q == ST_HOLD);
  assign buf_clear = (st_q == ST_IDLE) && cmd_start && (cmd_op == OP_PROG);
  assign in_ready  = (st_q == ST_LOAD) && !cs_rise;

  logic unused_armed;
  assign unused_armed = armed;
endmodule

// File: rtl/wseq_port.sv
// Array port: address, write strobe and read-modify-write data per sweep step.
module wseq_port
  import wseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 15
) (
  input  wseq_op_e                        op_q,
  input  logic [ADDR_W-1:PAGE_W]          page_q,
  input  logic [ADDR_W-1:0]               sweep_idx,
  input  logic                            in_sweep,
  input  logic [(1<<(ADDR_W-SECT_W))-1:0] sect_lock,
  input  logic [7:0]                      buf_data,
  input  logic                            buf_hit,
  input  logic [7:0]                      mem_rdata,
  output logic [PAGE_W-1:0]               buf_off,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic                            mem_we,
  output logic [7:0]                      mem_wdata
);
  localparam int SX_W  = ADDR_W - SECT_W;
  localparam int NSECT = 1 << SX_W;

  logic [NSECT-1:0] lock_sel;
  logic             cur_locked;

  for (genvar i = 0; i < NSECT; i++) begin : g_lock
    assign lock_sel[i] = sect_lock[i] && (sweep_idx[ADDR_W-1:SECT_W] == SX_W'(i));
  end
  assign cur_locked = |lock_sel;

  assign buf_off = sweep_idx[PAGE_W-1:0];

  always_comb begin
    mem_addr  = sweep_idx;
    mem_we    = 1'b0;
    mem_wdata = 8'hFF;
    case (op_q)
      OP_PROG: begin
        mem_addr  = {page_q, sweep_idx[PAGE_W-1:0]};
        mem_we    = in_sweep && buf_hit;
        mem_wdata = mem_rdata & buf_data;     // bits can only clear
      end
      OP_SERASE: begin
        mem_addr = {page_q[ADDR_W-1:SECT_W], sweep_idx[SECT_W-1:0]};
        mem_we   = in_sweep;
      end
      OP_CERASE: begin
        mem_addr = sweep_idx;
        mem_we   = in_sweep && !cur_locked;
      end
      default: mem_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
  import wseq_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter int          PAGE_W   = 8,
  parameter int          SECT_W   = 15,
  parameter int          HOLD_W   = 32,
  parameter int unsigned T_PROG   = 600,
  parameter int unsigned T_SERASE = 30000,
  parameter int unsigned T_CERASE = 105000,
  parameter int unsigned T_STAT   = 1800
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_start,
  input  logic [1:0]                      cmd_op,
  input  logic [ADDR_W-1:0]               cmd_addr,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [7:0]                      in_data,
  input  logic                            cs_rise,
  input  logic                            cs_aligned,
  input  logic [(1<<(ADDR_W-SECT_W))-1:0] sect_lock,
  output logic                            busy,
  output logic                            cycle_done,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic                            mem_we,
  output logic [7:0]                      mem_wdata,
  input  logic [7:0]                      mem_rdata
);
  wseq_op_e                op_q;
  logic [ADDR_W-1:PAGE_W]  page_q;
  logic [ADDR_W-1:0]       sweep_idx;
  logic                    in_sweep;
  logic                    buf_clear;
  logic [PAGE_W:0]         loaded_cnt;
  logic [PAGE_W-1:0]       buf_off;
  logic [7:0]              buf_data;
  logic                    buf_hit;

  wseq_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W), .HOLD_W(HOLD_W),
    .T_PROG(T_PROG), .T_SERASE(T_SERASE), .T_CERASE(T_CERASE), .T_STAT(T_STAT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_op     (wseq_op_e'(cmd_op)),
    .cmd_page   (cmd_addr[ADDR_W-1:PAGE_W]),
    .cs_rise    (cs_rise),
    .cs_aligned (cs_aligned),
    .loaded_cnt (loaded_cnt),
    .op_q       (op_q),
    .page_q     (page_q),
    .sweep_idx  (sweep_idx),
    .in_sweep   (in_sweep),
    .buf_clear  (buf_clear),
    .in_ready   (in_ready),
    .busy       (busy),
    .cycle_done (cycle_done)
  );

  wseq_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (buf_clear),
    .start_off  (cmd_addr[PAGE_W-1:0]),
    .ld_en      (in_valid && in_ready),
    .ld_data    (in_data),
    .rd_off     (buf_off),
    .rd_data    (buf_data),
    .rd_hit     (buf_hit),
    .loaded_cnt (loaded_cnt)
  );

  wseq_port #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W)) u_port (
    .op_q      (op_q),
    .page_q    (page_q),
    .sweep_idx (sweep_idx),
    .in_sweep  (in_sweep),
    .sect_lock (sect_lock),
    .buf_data  (buf_data),
    .buf_hit   (buf_hit),
    .mem_rdata (mem_rdata),
    .buf_off   (buf_off),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );
endmodule

// File: rtl/flash_wr_seq_chk.sv
module flash_wr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_rise,
  input logic       cs_aligned,
  input logic       in_ready,
  input logic       busy,
  input logic       cycle_done,
  input logic       mem_we,
  input logic [7:0] mem_wdata,
  input logic [7:0] mem_rdata
);
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);                                              // R2
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_aligned));                    // R5
  AST_WRITE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);                                                 // R5
  AST_CLEAR_ONLY_OR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata == 8'hFF) || ((mem_wdata & ~mem_rdata) == 8'h00))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !cycle_done);                                      // R10
  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> (!busy && $past(busy)));                           // R10
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cycle_done);                                      // R10
endmodule

bind flash_wr_seq flash_wr_seq_chk u_chk (.*);

// File: tb/flash_wr_seq_tb.sv
`timescale 1ns/1ps
module flash_wr_seq_tb;
  localparam int AW = 10, PW = 4, SW = 8;
  localparam int TP = 3, TSE = 20, TCE = 30, TST = 7;
  localparam int PB = 1 << PW, SB = 1 << SW, AB = 1 << AW, NS = 1 << (AW - SW);
  localparam logic [1:0] OPP = 2'b00, OPS = 2'b01, OPC = 2'b10, OPT = 2'b11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_start = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = 8'h00;
  logic          cs_rise = 1'b0;
  logic          cs_aligned = 1'b0;
  logic [NS-1:0] sect_lock = '0;
  logic          busy, cycle_done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  flash_wr_seq #(
    .ADDR_W(AW), .PAGE_W(PW), .SECT_W(SW), .HOLD_W(16),
    .T_PROG(TP), .T_SERASE(TSE), .T_CERASE(TCE), .T_STAT(TST)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
    .sect_lock(sect_lock), .busy(busy), .cycle_done(cycle_done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [AB];
  logic [7:0] exp_mem [AB];
  always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = mem[mem_addr];

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [AW-1:0] a);
    @(negedge clk);
    cmd_start = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send(logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic close(bit aligned, int exp_busy, string req);
    int n;
    cs_rise = 1'b1; cs_aligned = aligned;
    @(negedge clk);
    cs_rise = 1'b0; cs_aligned = 1'b0;
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp_busy, req, "busy cycles", n, exp_busy);
    chk(cycle_done == (exp_busy > 0), "R10", "done after busy", int'(cycle_done), int'(exp_busy > 0));
    @(negedge clk);
    chk(cycle_done == 1'b0, "R10", "done width", int'(cycle_done), 0);
  endtask

  task automatic compare_all(string req);
    int bad;
    bad = 0;
    for (int i = 0; i < AB; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, "array mismatches", bad, 0);
  endtask

  task automatic fill_exp(int lo, int hi);
    for (int i = lo; i < hi; i++) exp_mem[i] = 8'hFF;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int page, n, pos, stray;
    logic [7:0] pb [PB];
    bit tch [PB];
    logic [7:0] d;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !cycle_done && !in_ready && !mem_we, "R1", "outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cycle_done && !in_ready && !mem_we, "R1", "outputs after reset", int'(busy), 0);

    // R8: full chip erase
    issue(OPC, '0);
    close(1'b1, AB + TCE, "R8");
    fill_exp(0, AB);
    compare_all("R8");

    // R2: stray input bytes while idle
    stray = 0;
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; in_data = 8'h00;
      @(negedge clk);
      if (in_ready) stray++;
    end
    in_valid = 1'b0;
    chk(stray == 0, "R2", "ready while idle", stray, 0);
    issue(OPP, AW'(5 * PB + 9));
    send(8'h5A);
    close(1'b1, PB + TP, "R6");
    exp_mem[5 * PB + 9] = exp_mem[5 * PB + 9] & 8'h5A;
    compare_all("R2");

    // R4: reprogram ANDs into old contents
    issue(OPP, AW'(3));
    send(8'hA5);
    close(1'b1, PB + TP, "R6");
    issue(OPP, AW'(3));
    send(8'h3C);
    close(1'b1, PB + TP, "R6");
    exp_mem[3] = 8'h24;
    chk(mem[3] == 8'h24, "R4", "AND of programs", int'(mem[3]), 36);
    compare_all("R4");

    // R5: misaligned or empty commands are dropped
    issue(OPP, AW'(40));
    send(8'h00); send(8'h00); send(8'h00);
    close(1'b0, 0, "R5");
    compare_all("R5");
    issue(OPS, AW'(600));
    close(1'b0, 0, "R5");
    compare_all("R5");
    issue(OPP, AW'(70));
    close(1'b1, 0, "R5");
    compare_all("R5");

    // R3 / R6: every start offset, lengths past one page
    for (int off = 0; off < PB; off++) begin
      for (int len = 1; len <= PB + 4; len++) begin
        page = (off * 7 + len) % (AB / PB);
        n = 0;
        for (int p = 0; p < PB; p++) tch[p] = 1'b0;
        issue(OPP, AW'(page * PB + off));
        for (int k = 0; k < len; k++) begin
          d = 8'((off * 37 + len * 11 + k * 73 + 5) ^ (k * 3));
          pos = (off + k) % PB;
          pb[pos] = d;
          if (!tch[pos]) n++;
          tch[pos] = 1'b1;
          send(d);
        end
        for (int p = 0; p < PB; p++)
          if (tch[p]) exp_mem[page * PB + p] = exp_mem[page * PB + p] & pb[p];
        close(1'b1, PB + n * TP, "R6");
        compare_all("R3");
      end
    end

    // R7: sector erase from a mid-sector address
    issue(OPS, AW'(2 * SB + 8'h37));
    close(1'b1, SB + TSE, "R7");
    fill_exp(2 * SB, 3 * SB);
    compare_all("R7");

    // R8: chip erase with sector 1 locked
    sect_lock = NS'(4'b0010);
    issue(OPC, '0);
    close(1'b1, AB + TCE, "R8");
    fill_exp(0, SB);
    fill_exp(2 * SB, AB);
    compare_all("R8");
    sect_lock = '0;

    // R9: status write
    issue(OPT, '0);
    close(1'b1, TST, "R9");
    compare_all("R9");

    // R11: new command during busy is ignored
    issue(OPP, AW'(3 * SB + 3 * PB));
    send(8'h0F); send(8'hF0);
    exp_mem[3 * SB + 3 * PB]     = exp_mem[3 * SB + 3 * PB] & 8'h0F;
    exp_mem[3 * SB + 3 * PB + 1] = exp_mem[3 * SB + 3 * PB + 1] & 8'hF0;
    cs_rise = 1'b1; cs_aligned = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0; cs_aligned = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      n++;
      if (n == 3) begin cmd_start = 1'b1; cmd_op = OPC; cmd_addr = '0; end
      if (n == 5) begin cmd_start = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1; end
      if (n == 6) begin cs_rise = 1'b0; cs_aligned = 1'b0; end
      @(negedge clk);
    end
    chk(n == PB + 2 * TP, "R11", "busy with intrusion", n, PB + 2 * TP);
    chk(cycle_done == 1'b1, "R10", "done after intrusion", int'(cycle_done), 1);
    stray = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy) stray++;
    end
    chk(stray == 0, "R11", "no second cycle", stray, 0);
    compare_all("R11");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule